// File: doc/BRIEF.md
# Three-Wire Serial Memory Access Port

This block is a slave serial port. A host reaches a 14-bit byte-addressed space of memory and registers through it, using three wires: an active-low select, a serial clock and one shared data line. Each transfer opens with a two-byte header. The header carries the address and a direction flag. After the header, data bytes stream in or out, and the address advances by one after every byte. Every byte on the wire travels least significant bit first.

On the chip side, the port drives a simple synchronous byte port. Writes are single-cycle strobes that carry an address and data. Reads are single-cycle requests, and the data comes back on the next clock. The port also owns the output enable of the shared data pin. It turns the pin around after the header of a read and releases it when the select goes high. The port runs entirely in the system clock domain. It oversamples the serial clock and the select through two-flop synchronizers, so the system clock must run at least eight times faster than the serial clock.

In a read burst, the memory access for each byte is issued one byte ahead. Output bits change after each falling serial clock edge, so the host sees a settled bit at every rising edge.

Top module: `tw_serial_port`

## Requirements
- R1: A falling select starts a transfer. A high select at any time returns the port to idle at once: a partially received byte is never written, and the data pin output enable drops.
- R2: Data on the line is sampled at each rising serial clock edge. Bytes are assembled least significant bit first.
- R3: Bits 5..0 of the first header byte are address bits 13..8. Bit 6 is the direction flag: 0 means write and 1 means read. The second header byte holds address bits 7..0.
- R4: In a write transfer, each complete data byte produces exactly one single-cycle `mem_we` strobe with the current address and the byte. The address then increments and wraps from 0x3FFF to 0x0000. Writes never occur while the data pin is driven.
- R5: In a read transfer, `sda_oe` rises after the sixteenth rising edge and stays high until the select goes high.
- R6: In a read transfer, the byte at the current address is shifted out least significant bit first. Each bit is updated only after a falling serial clock edge, and successive bytes come from successive addresses, wrapping at 0x3FFF.
- R7: Bit 7 of the first header byte has no effect on the address or on the direction.
- R8: `mem_re` is a single-cycle request. The first request is issued when the header completes. Each later request is issued at the first falling edge of a byte, for the byte that follows.
- R9: After reset, `mem_we`, `mem_re`, `sda_oe` and `sda_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from host |
| ncs_i | input | 1 | Active-low transfer select |
| sda_i | input | 1 | Serial data from the pin |
| sda_o | output | 1 | Serial data toward the pin |
| sda_oe | output | 1 | Output enable for the shared data pin |
| mem_addr | output | 14 | Byte address for the access |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | Single-cycle read request |
| mem_rdata | input | 8 | Read data, valid one clock after `mem_re` |

## Verification
Each serial clock edge reaches the logic three system clocks later: two synchronizer stages plus the registered action. So the write strobe appears three clocks after the rising edge that completes a byte, and `sda_o` moves three clocks after a falling edge. The bench holds each serial clock level for eight system clocks. It samples the data pin just before it raises the clock, five clocks after the output settled. A scoreboard monitor runs on the opposite clock edge and compares every write strobe against the queued expectation the moment it occurs. The output enable and the read data are checked half a serial period after the edge that should change them.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_HI,
    ST_HDR_LO,
    ST_WRITE,
    ST_READ
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W            = 3,
  parameter int STAGES       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/tw_rx.sv
module tw_rx #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          rise,
  input  logic          sda,
  output logic [CW-1:0] cnt,
  output logic          byte_done,
  output logic [DW-1:0] byte_val
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh  <= '0;
      cnt <= '0;
    end else if (en && rise) begin
      sh  <= {sda, sh[DW-1:1]};
      cnt <= cnt + 1'b1;
    end
  end

  assign byte_done = en && rise && (cnt == CW'(DW-1));
  assign byte_val  = {sda, sh[DW-1:1]};
endmodule

// File: rtl/tw_tx.sv
module tw_tx #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          fall,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] load_val,
  output logic          sda_o
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh    <= '0;
      sda_o <= 1'b0;
    end else if (en && fall) begin
      if (cnt == '0) begin
        sh    <= load_val;
        sda_o <= load_val[0];
      end else begin
        sda_o <= sh[cnt];
      end
    end
  end

  AST_TX_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!fall && !clr) |=> $stable(sda_o)); // R6
endmodule

// File: rtl/tw_serial_port.sv
module tw_serial_port #(
  parameter int AW = 14,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_i,
  input  logic          ncs_i,
  input  logic          sda_i,
  output logic          sda_o,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata
);
  import tw_pkg::*;

  localparam int HI_W = AW - DW;
  localparam int CW   = $clog2(DW);

  logic [2:0]    sync_q;
  logic          s_sck, s_ncs, s_sda;
  logic          sck_q, ncs_q;
  logic          sck_rise, sck_fall, ncs_fall;
  logic [CW-1:0] bit_cnt;
  logic          byte_done;
  logic [DW-1:0] byte_val;
  tw_state_e     state;
  logic [HI_W:0] hdr_hi;
  logic [AW-1:0] ptr;
  logic          rd_pend;
  logic [DW-1:0] txbuf;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst(rst), .d({sda_i, ncs_i, sck_i}), .q(sync_q));

  assign s_sck = sync_q[0];
  assign s_ncs = sync_q[1];
  assign s_sda = sync_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b1;
      ncs_q <= 1'b1;
    end else begin
      sck_q <= s_sck;
      ncs_q <= s_ncs;
    end
  end

  assign sck_rise = s_sck & ~sck_q;
  assign sck_fall = ~s_sck & sck_q;
  assign ncs_fall = ~s_ncs & ncs_q;

  tw_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .clr(s_ncs), .en(state != ST_IDLE),
    .rise(sck_rise), .sda(s_sda), .cnt(bit_cnt),
    .byte_done(byte_done), .byte_val(byte_val));

  tw_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .clr(s_ncs), .en(state == ST_READ),
    .fall(sck_fall), .cnt(bit_cnt), .load_val(txbuf), .sda_o(sda_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hdr_hi    <= '0;
      ptr       <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      sda_oe    <= 1'b0;
      rd_pend   <= 1'b0;
      txbuf     <= '0;
    end else begin
      mem_we  <= 1'b0;
      mem_re  <= 1'b0;
      rd_pend <= mem_re;
      if (rd_pend) txbuf <= mem_rdata;
      if (s_ncs) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        if (state == ST_IDLE && ncs_fall) state <= ST_HDR_HI;
        if (byte_done) begin
          case (state)
            ST_HDR_HI: begin
              hdr_hi <= byte_val[HI_W:0];
              state  <= ST_HDR_LO;
            end
            ST_HDR_LO: begin
              if (hdr_hi[HI_W]) begin
                mem_re   <= 1'b1;
                mem_addr <= {hdr_hi[HI_W-1:0], byte_val};
                ptr      <= {hdr_hi[HI_W-1:0], byte_val} + 1'b1;
                sda_oe   <= 1'b1;
                state    <= ST_READ;
              end else begin
                ptr   <= {hdr_hi[HI_W-1:0], byte_val};
                state <= ST_WRITE;
              end
            end
            ST_WRITE: begin
              mem_we    <= 1'b1;
              mem_addr  <= ptr;
              mem_wdata <= byte_val;
              ptr       <= ptr + 1'b1;
            end
            default: ;
          endcase
        end
        if (state == ST_READ && sck_fall && bit_cnt == '0) begin
          mem_re   <= 1'b1;
          mem_addr <= ptr;
          ptr      <= ptr + 1'b1;
        end
      end
    end
  end

  AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (rst)
    s_ncs |=> !sda_oe); // R1
  AST_OE_HELD_WHILE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && !s_ncs) |=> sda_oe); // R5
  AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R4
  AST_WE_NOT_IN_READ: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !sda_oe); // R4
  AST_RE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re); // R8
  AST_RE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> sda_oe); // R8
endmodule

// File: tb/test_tw_serial_port.sv
module test_tw_serial_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b1, ncs = 1'b1, sda = 1'b0;
  logic        sda_o, sda_oe, mem_we, mem_re;
  logic [13:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int n_checks = 0;
  int n_fail   = 0;
  logic [21:0] wr_q[$];

  localparam int HALF = 8;

  always #2 clk = ~clk;

  tw_serial_port i_tw_serial_port (
    .clk(clk), .rst(rst), .sck_i(sck), .ncs_i(ncs), .sda_i(sda),
    .sda_o(sda_o), .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata));

  function automatic logic [7:0] pattern(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction

  always @(negedge clk) if (mem_re) mem_rdata <= pattern(mem_addr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (wr_q.size() == 0) begin
        check(1'b0, "R1/R4 unexpected write", {mem_addr, mem_wdata}, 0);
      end else begin
        logic [21:0] e;
        e = wr_q.pop_front();
        check({mem_addr, mem_wdata} == e, "R2/R3/R4/R7 write addr,data",
              {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sck = 1'b0; sda = b; wait_clk(HALF);
    sck = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic start_xfer();
    ncs = 1'b0; wait_clk(HALF);
  endtask

  task automatic end_xfer();
    ncs = 1'b1; sck = 1'b1; wait_clk(2 * HALF);
  endtask

  task automatic header(input logic [13:0] a, input logic rd, input logic ign);
    send_byte({ign, rd, a[13:8]});
    send_byte(a[7:0]);
  endtask

  task automatic write_burst(input logic [13:0] a, input int n, input logic ign);
    start_xfer();
    header(a, 1'b0, ign);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'hA0 + 8'(i * 37);
      wr_q.push_back({a + 14'(i), d});
      send_byte(d);
    end
    end_xfer();
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; wait_clk(HALF);
      b[i] = sda_o;
      sck = 1'b1; wait_clk(HALF);
    end
  endtask

  task automatic read_burst(input logic [13:0] a, input int n);
    logic [7:0] got;
    start_xfer();
    header(a, 1'b1, 1'b0);
    check(sda_oe == 1'b1, "R5 oe after header", sda_oe, 1);
    for (int i = 0; i < n; i++) begin
      read_byte(got);
      check(got == pattern(a + 14'(i)), "R6/R8 read byte", got, pattern(a + 14'(i)));
      check(sda_oe == 1'b1, "R5 oe held", sda_oe, 1);
    end
    end_xfer();
    check(sda_oe == 1'b0, "R1 oe released", sda_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] got;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    check({mem_we, mem_re, sda_oe, sda_o} == 4'b0, "R9 reset outputs",
          {mem_we, mem_re, sda_oe, sda_o}, 0);

    write_burst(14'h1234, 3, 1'b0);          // R2 R3 R4
    write_burst(14'h3FFE, 3, 1'b0);          // R4 wrap
    write_burst(14'h0155, 1, 1'b1);          // R7 ignored bit set
    read_burst(14'h0ABC, 3);                 // R5 R6 R8
    read_burst(14'h3FFF, 2);                 // R6 wrap

    // R7: ignored bit set on a read header keeps read direction
    start_xfer();
    header(14'h2001, 1'b1, 1'b1);
    check(sda_oe == 1'b1, "R7 read with bit7 set", sda_oe, 1);
    read_byte(got);
    check(got == pattern(14'h2001), "R7 read data", got, pattern(14'h2001));
    end_xfer();

    // R1: abort in the middle of a write byte
    start_xfer();
    header(14'h0777, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    end_xfer();
    wait_clk(4 * HALF);
    check(wr_q.size() == 0, "R1 no write after abort", wr_q.size(), 0);

    // R1: abort during a read releases the pin quickly
    start_xfer();
    header(14'h0100, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; wait_clk(HALF); sck = 1'b1; wait_clk(HALF);
    end
    ncs = 1'b1;
    wait_clk(6);
    check(sda_oe == 1'b0, "R1 oe dropped on abort", sda_oe, 0);
    sck = 1'b1; wait_clk(2 * HALF);

    // R1: new transfer works after aborts
    write_burst(14'h0042, 2, 1'b0);
    wait_clk(4 * HALF);
    check(wr_q.size() == 0, "R4 all writes seen", wr_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule